// File: doc/BRIEF.md
# Bottleneck Waiting-Cycle Table

This block is a single shared table, fully associative and keyed by a bottleneck identifier, that measures how much thread waiting each software bottleneck causes across all cores of a chip. A core signals that one of its threads has started waiting on a bottleneck with a wait-begin event. It signals that the thread has stopped waiting with a wait-end event. Both events carry the bottleneck ID. For every tracked ID the table keeps a count of the threads now waiting and a thread-waiting-cycle (TWC) accumulator. Every cycle, each accumulator grows by its entry's waiter count.

A scheduler reads the table through a query port that returns hit, waiter count, TWC and an acceleration flag for one ID. The flag is set when the TWC is strictly above a programmable threshold. The table also streams accelerate and decelerate notifications, one per cycle, whenever the flag of an entry differs from the last status it reported. A new ID takes a free entry. If no entry is free, it evicts the entry with the smallest TWC, so the least harmful bottleneck gives way.

An epoch controller halves all accumulators at a programmable interval, so the ranking follows changes over time. It has three states. EP_OFF is the state when the interval is zero. EP_COUNT counts cycles of the interval. EP_DECAY is the single halving cycle. Its transitions are as follows. EP_OFF→EP_COUNT when the interval becomes nonzero. EP_COUNT→EP_DECAY when the count reaches the interval. EP_DECAY→EP_COUNT, or →EP_OFF if the interval is now zero. EP_COUNT→EP_OFF when the interval is cleared.

Top module: `bwt_table`

## Requirements
- R1: The query port reports query_hit=1 with that entry's waiter count and TWC for any ID held in a valid entry, and query_hit=0 with zeros otherwise.
- R2: A wait-begin for an ID that is not tracked allocates the lowest-index free entry, with waiter count 1 and TWC 0 in the next cycle.
- R3: When no entry is free, the allocation replaces the entry with the smallest TWC (lowest index on a tie), and the evicted ID then misses.
- R4: A wait-begin that hits an entry raises its waiter count by one, holding at the maximum 2^WAIT_W-1. A wait-end that hits an entry lowers the count by one.
- R5: A waiter count of zero stays at zero on a wait-end. A wait-end for an untracked ID changes nothing.
- R6: A wait-begin and a wait-end that hit the same entry in the same cycle leave its waiter count unchanged.
- R7: In every cycle that is not a decay cycle, each valid entry's TWC grows by its waiter count as it stood before that cycle's events.
- R8: The TWC saturates at 2^ACC_W-1 and never wraps.
- R9: query_accel is 1 exactly when the queried ID hits and its TWC is strictly greater than threshold.
- R10: An entry whose acceleration flag differs from its last reported status raises note_vld with its ID and note_accel equal to the flag (1 accelerate, 0 decelerate). The lowest index goes first, one entry per cycle. A freshly allocated entry starts with a reported status of 0.
- R11: When epoch_len is N>0, after every N counting cycles there is one decay cycle. In it, every TWC becomes floor(TWC/2) and no waiting is added. When epoch_len is 0, no decay happens.
- R12: After reset no entry is valid: every query misses and note_vld is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_vld | input | 1 | Wait-begin event valid |
| wb_id | input | ID_W | Bottleneck ID of the wait-begin |
| we_vld | input | 1 | Wait-end event valid |
| we_id | input | ID_W | Bottleneck ID of the wait-end |
| threshold | input | ACC_W | Acceleration threshold on the TWC |
| epoch_len | input | EPOCH_W | Counting cycles between decays, 0 disables |
| query_id | input | ID_W | ID to look up |
| query_hit | output | 1 | Queried ID is tracked |
| query_waiters | output | WAIT_W | Waiter count of the queried ID |
| query_twc | output | ACC_W | Accumulated waiting cycles of the queried ID |
| query_accel | output | 1 | Queried ID is above threshold |
| note_vld | output | 1 | Status-change notification valid |
| note_id | output | ID_W | ID of the notified entry |
| note_accel | output | 1 | 1 accelerate, 0 decelerate |

## Verification
The table runs through directed sequences first. One sequence uses a few IDs, to show allocation, accumulation and threshold crossing in isolation. Another sets begin and end on the same ID in the same cycle, so that a cancelled update can be told apart from an ordered one. A third sends surplus and unknown wait-ends, to show the floor and the ignore rule. A fourth fills the table and then evicts under ties and under distinct TWCs, which separates minimum-TWC selection from index or age order. A long run with saturated waiters reaches the TWC ceiling. Raising and lowering the threshold produces decelerate notifications. A short epoch exposes the halving cycle. Finally a random stream with eight IDs over four entries, with a changing threshold and epoch, mixes eviction, notification priority and decay. A behavioural model checks every query field and notification on every cycle, with the query ID cycling through tracked and untracked values.

// File: rtl/bwt_pkg.sv
package bwt_pkg;
    typedef enum logic [1:0] {
        EP_OFF   = 2'd0,
        EP_COUNT = 2'd1,
        EP_DECAY = 2'd2
    } epoch_state_e;
endpackage

// File: rtl/bwt_epoch_fsm.sv
module bwt_epoch_fsm
    import bwt_pkg::*;
#(
    parameter int EPOCH_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [EPOCH_W-1:0] epoch_len,
    output logic               decay_o
);
    epoch_state_e       state_q, state_d;
    logic [EPOCH_W-1:0] cnt_q, cnt_d;
    logic [EPOCH_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + {{EPOCH_W{1'b0}}, 1'b1};

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            EP_OFF: begin
                cnt_d = '0;
                if (epoch_len != '0) state_d = EP_COUNT;
            end
            EP_COUNT: begin
                if (epoch_len == '0) begin
                    state_d = EP_OFF;
                    cnt_d   = '0;
                end else if (cnt_inc >= {1'b0, epoch_len}) begin
                    state_d = EP_DECAY;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_inc[EPOCH_W-1:0];
                end
            end
            EP_DECAY: begin
                cnt_d   = '0;
                state_d = (epoch_len == '0) ? EP_OFF : EP_COUNT;
            end
            default: begin
                state_d = EP_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EP_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        decay_o = (state_q == EP_DECAY);
    end

    // a decay cycle is always followed by a non-decay cycle (R11)
    p_single_decay_r11: assert property (@(posedge clk) disable iff (!rst_n)
        decay_o |=> !decay_o);
endmodule

// File: rtl/bwt_entry.sv
module bwt_entry #(
    parameter int ID_W   = 12,
    parameter int WAIT_W = 6,
    parameter int ACC_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [ID_W-1:0]   alloc_id_i,
    input  logic              begin_hit_i,
    input  logic              end_hit_i,
    input  logic              decay_i,
    input  logic              take_i,
    input  logic [ACC_W-1:0]  threshold_i,
    output logic              valid_o,
    output logic [ID_W-1:0]   id_o,
    output logic [WAIT_W-1:0] wait_o,
    output logic [ACC_W-1:0]  acc_o,
    output logic              hot_o,
    output logic              pub_o
);
    localparam logic [WAIT_W-1:0] WMAX = '1;
    localparam logic [ACC_W-1:0]  AMAX = '1;

    logic              valid_q, pub_q;
    logic [ID_W-1:0]   id_q;
    logic [WAIT_W-1:0] wait_q;
    logic [ACC_W-1:0]  acc_q, acc_add;
    logic [ACC_W:0]    sum;

    assign sum     = {1'b0, acc_q} + {{(ACC_W+1-WAIT_W){1'b0}}, wait_q};
    assign acc_add = sum[ACC_W] ? AMAX : sum[ACC_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            pub_q   <= 1'b0;
            id_q    <= '0;
            wait_q  <= '0;
            acc_q   <= '0;
        end else if (alloc_i) begin
            valid_q <= 1'b1;
            pub_q   <= 1'b0;
            id_q    <= alloc_id_i;
            wait_q  <= {{(WAIT_W-1){1'b0}}, 1'b1};
            acc_q   <= '0;
        end else if (valid_q) begin
            acc_q <= decay_i ? (acc_q >> 1) : acc_add;
            if (begin_hit_i && !end_hit_i && wait_q != WMAX)
                wait_q <= wait_q + 1'b1;
            else if (end_hit_i && !begin_hit_i && wait_q != '0)
                wait_q <= wait_q - 1'b1;
            if (take_i) pub_q <= hot_o;
        end
    end

    assign valid_o = valid_q;
    assign id_o    = id_q;
    assign wait_o  = wait_q;
    assign acc_o   = acc_q;
    assign pub_o   = pub_q;
    assign hot_o   = valid_q && (acc_q > threshold_i);

    p_alloc_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |=> valid_q && wait_q == 1 && acc_q == '0);

    p_wait_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q && !alloc_i && end_hit_i && !begin_hit_i && wait_q == '0
        |=> wait_q == '0);

    p_same_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q && !alloc_i && begin_hit_i && end_hit_i |=> $stable(wait_q));

    p_acc_grow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q && !alloc_i && !decay_i |=> acc_q >= $past(acc_q));

    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q && !alloc_i && !decay_i && acc_q == AMAX |=> acc_q == AMAX);
endmodule

// File: rtl/bwt_victim_sel.sv
module bwt_victim_sel #(
    parameter int ENTRIES = 32,
    parameter int ACC_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            valid_i,
    input  logic [ENTRIES-1:0][ACC_W-1:0] acc_i,
    output logic [IDX_W-1:0]              victim_o
);
    logic             found_free;
    logic [IDX_W-1:0] free_idx, min_idx;
    logic [ACC_W-1:0] min_acc;

    always_comb begin
        found_free = 1'b0;
        free_idx   = '0;
        min_idx    = '0;
        min_acc    = acc_i[0];
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid_i[i] && !found_free) begin
                found_free = 1'b1;
                free_idx   = IDX_W'(i);
            end
            if (acc_i[i] < min_acc) begin
                min_acc = acc_i[i];
                min_idx = IDX_W'(i);
            end
        end
        victim_o = found_free ? free_idx : min_idx;
    end
endmodule

// File: rtl/bwt_table.sv
module bwt_table #(
    parameter int ENTRIES = 32,
    parameter int ID_W    = 12,
    parameter int WAIT_W  = 6,
    parameter int ACC_W   = 20,
    parameter int EPOCH_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wb_vld,
    input  logic [ID_W-1:0]    wb_id,
    input  logic               we_vld,
    input  logic [ID_W-1:0]    we_id,
    input  logic [ACC_W-1:0]   threshold,
    input  logic [EPOCH_W-1:0] epoch_len,
    input  logic [ID_W-1:0]    query_id,
    output logic               query_hit,
    output logic [WAIT_W-1:0]  query_waiters,
    output logic [ACC_W-1:0]   query_twc,
    output logic               query_accel,
    output logic               note_vld,
    output logic [ID_W-1:0]    note_id,
    output logic               note_accel
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0]            ent_valid, ent_hot, ent_pub;
    logic [ENTRIES-1:0]            bhit_vec, ehit_vec, alloc_vec, take_vec;
    logic [ENTRIES-1:0][ACC_W-1:0] ent_acc;
    logic [ID_W-1:0]               ent_id   [ENTRIES];
    logic [WAIT_W-1:0]             ent_wait [ENTRIES];
    logic [IDX_W-1:0]              victim, pick_idx;
    logic                          begin_miss, decay;

    bwt_epoch_fsm #(.EPOCH_W(EPOCH_W)) epoch_i (
        .clk(clk), .rst_n(rst_n), .epoch_len(epoch_len), .decay_o(decay)
    );

    bwt_victim_sel #(.ENTRIES(ENTRIES), .ACC_W(ACC_W)) victim_i (
        .valid_i(ent_valid), .acc_i(ent_acc), .victim_o(victim)
    );

    // lookup of both event ports
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            bhit_vec[i] = wb_vld && ent_valid[i] && (ent_id[i] == wb_id);
            ehit_vec[i] = we_vld && ent_valid[i] && (ent_id[i] == we_id);
        end
        begin_miss = wb_vld && (bhit_vec == '0);
        for (int i = 0; i < ENTRIES; i++)
            alloc_vec[i] = begin_miss && (victim == IDX_W'(i));
    end

    // notification pick: lowest index whose status changed
    always_comb begin
        note_vld = 1'b0;
        pick_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!note_vld && ent_valid[i] && (ent_hot[i] != ent_pub[i])) begin
                note_vld = 1'b1;
                pick_idx = IDX_W'(i);
            end
        end
        for (int i = 0; i < ENTRIES; i++)
            take_vec[i] = note_vld && (pick_idx == IDX_W'(i));
        note_id    = ent_id[pick_idx];
        note_accel = ent_hot[pick_idx];
    end

    // query port
    always_comb begin
        query_hit     = 1'b0;
        query_waiters = '0;
        query_twc     = '0;
        query_accel   = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (ent_valid[i] && ent_id[i] == query_id) begin
                query_hit     = 1'b1;
                query_waiters = ent_wait[i];
                query_twc     = ent_acc[i];
                query_accel   = ent_hot[i];
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        bwt_entry #(.ID_W(ID_W), .WAIT_W(WAIT_W), .ACC_W(ACC_W)) ent_i (
            .clk(clk), .rst_n(rst_n),
            .alloc_i(alloc_vec[g]), .alloc_id_i(wb_id),
            .begin_hit_i(bhit_vec[g]), .end_hit_i(ehit_vec[g]),
            .decay_i(decay), .take_i(take_vec[g]), .threshold_i(threshold),
            .valid_o(ent_valid[g]), .id_o(ent_id[g]), .wait_o(ent_wait[g]),
            .acc_o(ent_acc[g]), .hot_o(ent_hot[g]), .pub_o(ent_pub[g])
        );
    end

    // allocation only ever targets one entry (R2)
    p_one_alloc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_vec));

    // a notification for an entry is not repeated unless its status moves (R10)
    p_note_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        note_vld && !wb_vld && !decay && $stable(threshold) && note_accel
        |=> !(note_vld && note_id == $past(note_id) && note_accel));
endmodule

// File: tb/bwt_table_tb.sv
`timescale 1ns/1ps
module bwt_table_tb_top;
    localparam int NE = 4, IDW = 4, WW = 3, AW = 8, EW = 6;
    localparam int WMAX = (1 << WW) - 1;
    localparam int AMAX = (1 << AW) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wb_vld = 0, we_vld = 0;
    logic [IDW-1:0] wb_id = '0, we_id = '0, query_id = '0;
    logic [AW-1:0] threshold = '0;
    logic [EW-1:0] epoch_len = '0;
    logic query_hit, query_accel, note_vld, note_accel;
    logic [WW-1:0] query_waiters;
    logic [AW-1:0] query_twc;
    logic [IDW-1:0] note_id;

    always #2.5 clk = ~clk;

    bwt_table #(.ENTRIES(NE), .ID_W(IDW), .WAIT_W(WW), .ACC_W(AW), .EPOCH_W(EW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wb_vld(wb_vld), .wb_id(wb_id),
        .we_vld(we_vld), .we_id(we_id), .threshold(threshold), .epoch_len(epoch_len),
        .query_id(query_id), .query_hit(query_hit), .query_waiters(query_waiters),
        .query_twc(query_twc), .query_accel(query_accel), .note_vld(note_vld),
        .note_id(note_id), .note_accel(note_accel)
    );

    int compared = 0, mismatched = 0;
    bit done = 0;
    string phase = "R12";
    int qsel = 0;

    // behavioural reference
    bit m_valid[NE];
    int m_id[NE], m_wait[NE], m_acc[NE];
    bit m_pub[NE];
    int ep_state = 0, ep_cnt = 0;

    task automatic chk(string fld, int got, int exp);
        compared++;
        if (got != exp) begin
            mismatched++;
            $display("FAIL %s %s: got %0d expected %0d (t=%0t)", phase, fld, got, exp, $time);
        end
    endtask

    function automatic int find(int id);
        for (int i = 0; i < NE; i++) if (m_valid[i] && m_id[i] == id) return i;
        return -1;
    endfunction

    function automatic int pick();
        for (int i = 0; i < NE; i++)
            if (m_valid[i] && ((m_acc[i] > int'(threshold)) != m_pub[i])) return i;
        return -1;
    endfunction

    task automatic compare_all();
        int q = find(int'(query_id));
        int p = pick();
        chk("query_hit R1", int'(query_hit), q >= 0);
        chk("query_waiters R4", int'(query_waiters), q >= 0 ? m_wait[q] : 0);
        chk("query_twc R7", int'(query_twc), q >= 0 ? m_acc[q] : 0);
        chk("query_accel R9", int'(query_accel), q >= 0 ? int'(m_acc[q] > int'(threshold)) : 0);
        chk("note_vld R10", int'(note_vld), p >= 0);
        if (p >= 0) begin
            chk("note_id R10", int'(note_id), m_id[p]);
            chk("note_accel R10", int'(note_accel), int'(m_acc[p] > int'(threshold)));
        end
    endtask

    task automatic model_step();
        bit dec = (ep_state == 2);
        int bh = wb_vld ? find(int'(wb_id)) : -1;
        int eh = we_vld ? find(int'(we_id)) : -1;
        int al = -1;
        int p = pick();
        if (wb_vld && bh < 0) begin
            for (int i = NE - 1; i >= 0; i--) if (!m_valid[i]) al = i;
            if (al < 0) begin
                al = 0;
                for (int i = 1; i < NE; i++) if (m_acc[i] < m_acc[al]) al = i;
            end
        end
        for (int i = 0; i < NE; i++) begin
            if (i == al) begin
                m_valid[i] = 1; m_id[i] = int'(wb_id); m_wait[i] = 1; m_acc[i] = 0; m_pub[i] = 0;
            end else if (m_valid[i]) begin
                int na = dec ? m_acc[i] / 2 : ((m_acc[i] + m_wait[i] > AMAX) ? AMAX : m_acc[i] + m_wait[i]);
                if (i == p) m_pub[i] = m_acc[i] > int'(threshold);
                if (i == bh && i != eh && m_wait[i] < WMAX) m_wait[i]++;
                else if (i == eh && i != bh && m_wait[i] > 0) m_wait[i]--;
                m_acc[i] = na;
            end
        end
        case (ep_state)
            0: begin ep_cnt = 0; if (epoch_len != 0) ep_state = 1; end
            1: begin
                if (epoch_len == 0) begin ep_state = 0; ep_cnt = 0; end
                else if (ep_cnt + 1 >= int'(epoch_len)) begin ep_state = 2; ep_cnt = 0; end
                else ep_cnt++;
            end
            default: begin ep_cnt = 0; ep_state = (epoch_len == 0) ? 0 : 1; end
        endcase
    endtask

    // one clock: inputs are already applied at the falling edge
    task automatic cyc(bit bv, int bid, bit ev, int eid);
        wb_vld = bv; wb_id = IDW'(bid); we_vld = ev; we_id = IDW'(eid);
        query_id = IDW'(qsel % 8); qsel++;
        #1;
        compare_all();
        model_step();
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NE; i++) begin m_valid[i] = 0; m_id[i] = 0; m_wait[i] = 0; m_acc[i] = 0; m_pub[i] = 0; end
        // R12: reset state, checked while in reset and just after release
        repeat (3) @(negedge clk);
        #1; compare_all();
        rst_n = 1'b1;
        @(negedge clk);
        idle(3);

        // R2, R4, R7, R9, R10: allocation, increment, accumulation, crossing
        phase = "R2";
        threshold = 8'd10;
        cyc(1, 5, 0, 0);
        cyc(1, 9, 0, 0);
        phase = "R4";
        cyc(1, 5, 0, 0);
        phase = "R9";
        idle(12);

        // R6: begin and end on one ID in one cycle
        phase = "R6";
        cyc(1, 5, 1, 5);
        idle(2);

        // R5: surplus wait-ends and an unknown ID
        phase = "R5";
        cyc(0, 0, 1, 9);
        cyc(0, 0, 1, 9);
        cyc(0, 0, 1, 9);
        cyc(0, 0, 1, 7);
        idle(2);

        // R3: fill the table, then evict by minimum TWC with ties
        phase = "R3";
        cyc(1, 1, 0, 0);
        cyc(1, 2, 0, 0);
        idle(3);
        cyc(1, 3, 0, 0);
        cyc(1, 4, 0, 0);
        idle(2);
        cyc(1, 6, 1, 5);

        // R8: saturate waiters and then the accumulator; move threshold
        phase = "R8";
        for (int k = 0; k < 9; k++) cyc(1, 6, 0, 0);
        idle(45);
        phase = "R10";
        threshold = 8'd254;
        idle(3);
        threshold = 8'd255;
        idle(3);
        threshold = 8'd20;
        idle(3);

        // R11: short epoch, then disable
        phase = "R11";
        epoch_len = 6'd5;
        idle(25);
        epoch_len = 6'd0;
        idle(6);

        // mixed random traffic, eight IDs over four entries
        phase = "R3";
        for (int k = 0; k < 600; k++) begin
            if (k % 50 == 0) threshold = AW'($urandom_range(0, 120));
            if (k % 150 == 0) epoch_len = EW'($urandom_range(0, 12));
            cyc(($urandom_range(0, 3) == 0), $urandom_range(0, 7),
                ($urandom_range(0, 2) == 0), $urandom_range(0, 7));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule